// File: doc/BRIEF.md
# MDIO PHY Address Match Unit

This block sits on the PHY side of a serial management link. It samples the management data line on every rising edge of the management clock. It finds the start of each frame, collects the five-bit PHY address field and decides whether this PHY is the target of the transaction. The result is a single respond flag. A register access engine next to the block uses that flag to decide whether to take part in the turnaround and data phases.

A frame begins with a run of idle ones, then the two-bit start pattern, then a two-bit opcode, then the PHY address. Address zero is a broadcast address. A compliant PHY answers it whatever its own address is. A strap input can turn that broadcast answer off for PHYs that must not honour it. The configured own address is only accepted inside a legal range of 1 to 7. An own address outside that range never matches.

After a match, the respond flag stays high through the register address, turnaround and data fields. It drops on the edge that samples the last data bit, and the unit then returns to hunting for a preamble. A frame with a bad start pattern or a bad opcode is dropped without raising the flag.

Top module: `mdio_phyaddr_match`

## Requirements
- R1: While reset is high, and on the first edge after it, respond is 0 and the unit is hunting for a preamble. A reset in the middle of a frame clears respond at the next edge.
- R2: A frame is recognised only after at least 32 consecutive sampled ones followed by the start pattern 0 then 1. With 31 ones the frame is ignored and respond stays 0. With 32 or more ones the frame is accepted.
- R3: The address field is the five bits sampled right after the opcode, most significant bit first. Respond goes high on the rising edge that samples the fifth address bit when that address equals the own address.
- R4: Address 00000 raises respond when bcast_en is 1, and does not raise it when bcast_en is 0.
- R5: An own address of 0 or greater than 7 never matches; respond can then rise only through the broadcast address.
- R6: The opcode is the two bits after the start pattern. Only 10 (read) and 01 (write) are valid. The values 00 and 11 abort the frame with respond left at 0.
- R7: A start pattern of 0 then 0 after a valid preamble returns the unit to preamble hunting with respond left at 0.
- R8: Once raised, respond stays high for exactly 23 edges: register address (5), turnaround (2) and data (16). It falls on the edge that samples the last data bit. An address that does not match leaves respond at 0 for the whole frame.
- R9: After a frame ends, the next frame is recognised only after a fresh preamble of at least 32 ones. A frame that directly follows with no preamble is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Management clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_in | input | 1 | Sampled management data line |
| own_addr | input | 5 | Configured PHY address, legal range 1 to 7 |
| bcast_en | input | 1 | 1 lets address 00000 act as a broadcast match |
| respond | output | 1 | High while the current frame is addressed to this PHY |

## Verification
The bench sends frames addressed to the own address, to other addresses and to address zero, with the broadcast strap both on and off. This separates a real match, a non-match and a broadcast match. Preambles of 31, 32 and 40 ones test the preamble length threshold. A bad start pattern, both invalid opcodes and a frame sent back to back with no preamble each have to leave respond low. An illegal own address of 0 and of 9 shows that only the broadcast path can still fire. A reset in the middle of a frame and the 23-edge hold window test when respond is released.

// File: rtl/mdio_am_pkg.sv
package mdio_am_pkg;

    localparam int MAM_ADDR_W   = 5;
    localparam int MAM_PRE_LEN  = 32;
    localparam int MAM_OP_W     = 2;
    localparam int MAM_REGAD_W  = 5;
    localparam int MAM_TA_W     = 2;
    localparam int MAM_DATA_W   = 16;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OPC,
        ST_ADDR,
        ST_REST
    } mam_state_e;

    function automatic logic opcode_ok(input logic [1:0] op);
        return (op == OPC_READ) || (op == OPC_WRITE);
    endfunction

endpackage

// File: rtl/mdio_pre_det.sv
module mdio_pre_det #(
    parameter int PRE_LEN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic hunting,
    input  logic bit_in,
    output logic pre_sat
);
    localparam int PRE_W = $clog2(PRE_LEN + 1);

    logic [PRE_W-1:0] ones_q;

    assign pre_sat = (ones_q == PRE_W'(PRE_LEN));

    always_ff @(posedge clk) begin
        if (rst || !hunting || !bit_in) begin
            ones_q <= '0;
        end else if (!pre_sat) begin
            ones_q <= ones_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_field_shift.sv
module mdio_field_shift #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] field_q,
    output logic [W-1:0] field_next
);
    assign field_next = {field_q[W-2:0], bit_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
        end else if (shift_en) begin
            field_q <= field_next;
        end
    end
endmodule

// File: rtl/mdio_addr_cmp.sv
module mdio_addr_cmp #(
    parameter int ADDR_W   = 5,
    parameter int OWN_MIN  = 1,
    parameter int OWN_MAX  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bcast_en,
    output logic              hit
);
    logic own_legal;
    logic own_hit;
    logic bc_hit;

    assign own_legal = (own_addr >= ADDR_W'(OWN_MIN)) && (own_addr <= ADDR_W'(OWN_MAX));
    assign own_hit   = own_legal && (addr == own_addr);
    assign bc_hit    = bcast_en && (addr == '0);
    assign hit       = own_hit || bc_hit;
endmodule

// File: rtl/mdio_phyaddr_match.sv
module mdio_phyaddr_match
    import mdio_am_pkg::*;
#(
    parameter int ADDR_W  = MAM_ADDR_W,
    parameter int PRE_LEN = MAM_PRE_LEN,
    parameter int REGAD_W = MAM_REGAD_W,
    parameter int TA_W    = MAM_TA_W,
    parameter int DATA_W  = MAM_DATA_W,
    parameter int OWN_MIN = 1,
    parameter int OWN_MAX = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bcast_en,
    output logic              respond
);
    localparam int REST_LEN = REGAD_W + TA_W + DATA_W;
    localparam int CNT_W    = $clog2(REST_LEN + 1);

    mam_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              resp_q, resp_d;
    logic              pre_sat;
    logic              shift_en;
    logic              hit;
    logic [ADDR_W-1:0] field_q;
    logic [ADDR_W-1:0] field_next;

    mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .hunting (state_q == ST_HUNT),
        .bit_in  (mdio_in),
        .pre_sat (pre_sat)
    );

    assign shift_en = (state_q == ST_OPC) || (state_q == ST_ADDR);

    mdio_field_shift #(.W(ADDR_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .bit_in     (mdio_in),
        .field_q    (field_q),
        .field_next (field_next)
    );

    mdio_addr_cmp #(
        .ADDR_W  (ADDR_W),
        .OWN_MIN (OWN_MIN),
        .OWN_MAX (OWN_MAX)
    ) u_cmp (
        .addr     (field_next),
        .own_addr (own_addr),
        .bcast_en (bcast_en),
        .hit      (hit)
    );

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        resp_d  = resp_q;
        unique case (state_q)
            ST_HUNT: begin
                if (!mdio_in && pre_sat) begin
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (mdio_in) begin
                    state_d = ST_OPC;
                    cnt_d   = CNT_W'(MAM_OP_W - 1);
                end else begin
                    state_d = ST_HUNT;
                end
            end
            ST_OPC: begin
                if (cnt_q == '0) begin
                    if (opcode_ok(field_next[1:0])) begin
                        state_d = ST_ADDR;
                        cnt_d   = CNT_W'(ADDR_W - 1);
                    end else begin
                        state_d = ST_HUNT;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_ADDR: begin
                if (cnt_q == '0) begin
                    state_d = ST_REST;
                    cnt_d   = CNT_W'(REST_LEN - 1);
                    resp_d  = hit;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_REST: begin
                if (cnt_q == '0) begin
                    state_d = ST_HUNT;
                    resp_d  = 1'b0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_HUNT;
                resp_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            resp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            resp_q  <= resp_d;
        end
    end

    assign respond = resp_q;
endmodule

// File: rtl/mdio_phyaddr_match_chk.sv
module mdio_phyaddr_match_chk
    import mdio_am_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REST_LEN = 23,
    parameter int OWN_MIN  = 1,
    parameter int OWN_MAX  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              respond,
    input logic [ADDR_W-1:0] own_addr,
    input logic              bcast_en,
    input mam_state_e        state_q,
    input logic [ADDR_W-1:0] field_q,
    input logic              pre_sat
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !respond) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R1: reset clears the flag
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !respond);

    // R2: start phase is entered only from a saturated preamble hunt
    assert_start_after_pre_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START) |-> (($past(state_q) == ST_HUNT) && $past(pre_sat)));

    // R3 / R4 / R5: a rising flag is justified by the captured address
    assert_rise_justified_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(respond) |->
            ((bcast_en && (field_q == '0)) ||
             ((field_q == own_addr) && (own_addr >= ADDR_W'(OWN_MIN)) &&
              (own_addr <= ADDR_W'(OWN_MAX)))));

    // R8: the flag only lives in the tail of a frame
    assert_resp_in_tail_R8: assert property (@(posedge clk) disable iff (rst)
        respond |-> (state_q == ST_REST));

    // R8: hold window length
    assert_hold_len_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(respond) && !$past(rst)) |-> (hi_cnt == 8'(REST_LEN)));
endmodule

bind mdio_phyaddr_match mdio_phyaddr_match_chk #(
    .ADDR_W   (ADDR_W),
    .REST_LEN (REST_LEN),
    .OWN_MIN  (OWN_MIN),
    .OWN_MAX  (OWN_MAX)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .respond  (respond),
    .own_addr (own_addr),
    .bcast_en (bcast_en),
    .state_q  (state_q),
    .field_q  (field_q),
    .pre_sat  (pre_sat)
);

// File: tb/mdio_phyaddr_match_bench.sv
`timescale 1ns/1ps
module mdio_phyaddr_match_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mdio_in = 1'b1;
    logic [4:0] own_addr = 5'd3;
    logic       bcast_en = 1'b1;
    logic       respond;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic  bitq[$];
    logic  expq[$];
    string tagq[$];

    always #2.5 clk = ~clk;

    mdio_phyaddr_match u_mdio_phyaddr_match (
        .clk      (clk),
        .rst      (rst),
        .mdio_in  (mdio_in),
        .own_addr (own_addr),
        .bcast_en (bcast_en),
        .respond  (respond)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: respond=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // one bit per clock: drive on falling edge, check after rising edge
    task automatic play(input int n);
        for (int i = 0; i < n && bitq.size() > 0; i++) begin
            logic  b;
            logic  e;
            string t;
            b = bitq.pop_front();
            e = expq.pop_front();
            t = tagq.pop_front();
            @(negedge clk);
            mdio_in = b;
            @(posedge clk);
            #1;
            check(respond, e, t);
        end
    endtask

    function automatic logic addr_hits(input logic [4:0] a, input logic [4:0] own, input logic be);
        return (be && a == 5'd0) || (a == own && own >= 5'd1 && own <= 5'd7);
    endfunction

    // builds the bit stream of one frame and the expected flag after each edge
    task automatic push_frame(input int pre_len, input logic [1:0] st, input logic [1:0] op,
                              input logic [4:0] addr, input string tag);
        logic wf;
        logic m;
        logic [22:0] tail;
        wf   = (pre_len >= 32) && (st == 2'b01) && (op == 2'b10 || op == 2'b01);
        m    = wf && addr_hits(addr, own_addr, bcast_en);
        tail = {5'b10110, 2'b10, 16'h3C5A};
        for (int i = 0; i < pre_len; i++) begin
            bitq.push_back(1'b1); expq.push_back(1'b0); tagq.push_back(tag);
        end
        for (int i = 1; i >= 0; i--) begin
            bitq.push_back(st[i]); expq.push_back(1'b0); tagq.push_back(tag);
        end
        if (pre_len >= 32 && st != 2'b01) return;
        for (int i = 1; i >= 0; i--) begin
            bitq.push_back(op[i]); expq.push_back(1'b0); tagq.push_back(tag);
        end
        if (pre_len >= 32 && !(op == 2'b10 || op == 2'b01)) return;
        for (int i = 4; i >= 0; i--) begin
            bitq.push_back(addr[i]); expq.push_back(i == 0 ? m : 1'b0); tagq.push_back(tag);
        end
        for (int j = 0; j < 23; j++) begin
            bitq.push_back(tail[22-j]); expq.push_back(j < 22 ? m : 1'b0); tagq.push_back(tag);
        end
    endtask

    task automatic run_frame(input int pre_len, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] addr, input string tag);
        push_frame(pre_len, st, op, addr, tag);
        play(bitq.size());
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(respond, 1'b0, "R1 reset held");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(respond, 1'b0, "R1 after release");

        // R3: own address match, read and write
        own_addr = 5'd3; bcast_en = 1'b1;
        run_frame(32, 2'b01, 2'b10, 5'd3, "R3 own read");
        run_frame(40, 2'b01, 2'b01, 5'd3, "R3 own write long pre");
        // R8: non-matching addresses
        run_frame(32, 2'b01, 2'b10, 5'd5, "R8 other addr");
        run_frame(32, 2'b01, 2'b10, 5'd19, "R8 msb-first 10011 vs 00011");
        // R4: broadcast on and off
        run_frame(32, 2'b01, 2'b10, 5'd0, "R4 broadcast on");
        bcast_en = 1'b0;
        run_frame(32, 2'b01, 2'b01, 5'd0, "R4 broadcast off");
        run_frame(32, 2'b01, 2'b01, 5'd3, "R3 own with bcast off");
        bcast_en = 1'b1;
        // R2: preamble threshold
        run_frame(31, 2'b01, 2'b10, 5'd3, "R2 pre 31");
        run_frame(32, 2'b01, 2'b10, 5'd3, "R2 pre 32");
        // R6: invalid opcodes
        run_frame(32, 2'b01, 2'b11, 5'd3, "R6 op 11");
        run_frame(32, 2'b01, 2'b00, 5'd3, "R6 op 00");
        run_frame(32, 2'b01, 2'b10, 5'd3, "R6 recover");
        // R7: bad start
        run_frame(32, 2'b00, 2'b10, 5'd3, "R7 start 00");
        run_frame(32, 2'b01, 2'b10, 5'd3, "R7 recover");
        // R9: back-to-back without preamble
        push_frame(32, 2'b01, 2'b10, 5'd3, "R9 first");
        push_frame(0, 2'b01, 2'b10, 5'd3, "R9 no pre");
        push_frame(32, 2'b01, 2'b01, 5'd3, "R9 fresh pre");
        play(bitq.size());
        // R5: illegal own addresses
        own_addr = 5'd0; bcast_en = 1'b0;
        run_frame(32, 2'b01, 2'b10, 5'd0, "R5 own 0 bcast off");
        own_addr = 5'd9; bcast_en = 1'b0;
        run_frame(32, 2'b01, 2'b10, 5'd9, "R5 own 9");
        bcast_en = 1'b1;
        run_frame(32, 2'b01, 2'b10, 5'd0, "R5 own 9 bcast path");
        own_addr = 5'd7;
        run_frame(32, 2'b01, 2'b10, 5'd7, "R5 own 7 upper edge");
        own_addr = 5'd1;
        run_frame(32, 2'b01, 2'b01, 5'd1, "R5 own 1 lower edge");
        // R1: reset mid-frame
        push_frame(32, 2'b01, 2'b10, 5'd1, "R1 pre-reset");
        play(32 + 2 + 2 + 5 + 4);
        check(respond, 1'b1, "R1 flag up before reset");
        bitq.delete(); expq.delete(); tagq.delete();
        @(negedge clk);
        rst = 1'b1; mdio_in = 1'b1;
        @(posedge clk);
        #1;
        check(respond, 1'b0, "R1 mid-frame reset");
        @(negedge clk);
        rst = 1'b0;
        run_frame(32, 2'b01, 2'b10, 5'd1, "R1 after mid reset");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule